// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for a speculative core that executes out of order. An issuing instruction claims the slot at the tail and receives that slot's index as its rename tag. Execution units later broadcast a result with its tag on a shared result bus, and the buffer stores the value in that slot and marks the slot complete. Slots retire strictly from the head, one per cycle. A register operation writes the architectural register file. A store is sent to memory. A branch either retires with no effect or, if it was mispredicted, empties the whole buffer and redirects fetch to the correct target.

Issue logic can look up a tag to read a result that is complete but has not yet retired. The buffer does not arbitrate the result bus, hold operands or predict branches. Those functions sit outside and appear only as ports.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `issueReady` is 1, `issueTag` is 0, `lookupHit` is 0, and none of `commitRegValid`, `commitStoreValid` or `redirectValid` is asserted.
- R2: Each accepted issue (`issueValid` and `issueReady` both 1 at a clock edge) takes the slot named by `issueTag`. Successive accepted issues receive consecutive tags that wrap from DEPTH-1 back to 0.
- R3: `issueKind` encodes the entry type: 2'b00 is a register operation (destination is a register index), 2'b01 is a store (destination is a memory address, value is the store data), 2'b10 is a branch (the value is the correct target).
- R4: While DEPTH entries are outstanding, `issueReady` is 0 and an asserted `issueValid` allocates nothing.
- R5: A writeback marks its slot complete and stores `wbValue`. The head entry retires in the cycle after it is complete. An entry that completes before an older one never retires ahead of it, and at most one entry retires per cycle.
- R6: When a completed register operation reaches the head, `commitRegValid` is 1 for one cycle and carries its destination and value.
- R7: When a completed store reaches the head, `commitStoreValid` is 1 for one cycle with its address and data, and no register commit occurs.
- R8: When a completed branch whose writeback carried `wbMispredict`=1 reaches the head, `redirectValid` is 1 for one cycle with the branch's target. After that edge the buffer is empty, no younger entry ever retires, and the next issue receives the tag that follows the branch's slot.
- R9: A completed branch written back with `wbMispredict`=0 retires with none of the three commit outputs asserted.
- R10: `lookupHit` is 1, and `lookupValue` holds the result, for a tag whose slot is allocated and complete but not yet retired. Once the slot retires, `lookupHit` for that tag is 0.
- R11: A writeback whose tag names a free slot has no effect: a lookup of that tag misses, and a later allocation of the slot starts incomplete.
- R12: An accepted issue in the same cycle as a retirement leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Request to allocate an entry |
| issueKind | input | 2 | Entry type (R3 encoding) |
| issueDest | input | DEST_W | Register index or store address |
| issueReady | output | 1 | A slot is free and no flush is under way |
| issueTag | output | log2(DEPTH) | Tag given to the instruction issued this cycle |
| wbValid | input | 1 | Result bus carries a result |
| wbTag | input | log2(DEPTH) | Tag of the completing entry |
| wbValue | input | DATA_W | Result, store data or branch target |
| wbMispredict | input | 1 | Branch outcome differs from the prediction |
| lookupTag | input | log2(DEPTH) | Tag whose completed value is requested |
| lookupHit | output | 1 | Tagged slot is allocated and complete |
| lookupValue | output | DATA_W | Value held by the tagged slot |
| commitRegValid | output | 1 | Register write from the head entry |
| commitRegDest | output | DEST_W | Destination register index |
| commitRegValue | output | DATA_W | Value to write |
| commitStoreValid | output | 1 | Memory write from the head entry |
| commitStoreAddr | output | DEST_W | Store address |
| commitStoreData | output | DATA_W | Store data |
| redirectValid | output | 1 | Mispredicted branch retired, buffer flushed |
| redirectTarget | output | DATA_W | Correct fetch address |

## Verification
Two things can happen in the same cycle: a new instruction is allocated at the tail and an old one retires from the head. The bench fills the buffer to one short of full. It then writes back the head and issues in the very next cycle, so the allocation lands on the edge where the head retires. This is judged at the ports. `issueReady` must still be high afterwards, exactly one more issue must then make it drop, and the whole drained sequence must retire in order with the stalled request absent. A flush with completed younger entries waiting behind the branch is also staged, and it is judged by the redirect and by those entries never retiring.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } entryKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic commit;
    logic flush;
  } robStrobe_t;

endpackage

// File: rtl/reorder_ctrl.sv
module reorder_ctrl
  import reorder_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issueValid,
  input  logic             headReady,
  input  entryKind_e       headKind,
  input  logic             headMispredict,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [CNT_W-1:0] occupancy,
  output logic             issueReady
);

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic headValid, isFull, commitGo, flushGo;

  always_comb begin
    headValid     = (occupancy != '0);
    isFull        = (occupancy == CNT_W'(DEPTH));
    commitGo      = headValid && headReady;
    flushGo       = commitGo && (headKind == KIND_BRANCH) && headMispredict;
    issueReady    = !isFull && !flushGo;
    strobe.alloc  = issueValid && issueReady;
    strobe.commit = commitGo;
    strobe.flush  = flushGo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      occupancy <= '0;
    end else if (strobe.flush) begin
      headIdx   <= bump(headIdx);
      tailIdx   <= bump(headIdx);
      occupancy <= '0;
    end else begin
      if (strobe.commit) headIdx <= bump(headIdx);
      if (strobe.alloc)  tailIdx <= bump(tailIdx);
      occupancy <= occupancy + CNT_W'(strobe.alloc) - CNT_W'(strobe.commit);
    end
  end

endmodule

// File: rtl/reorder_data.sv
module reorder_data
  import reorder_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  parameter  int DEST_W = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  allocIdx,
  input  entryKind_e        allocKind,
  input  logic [DEST_W-1:0] allocDest,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbMispredict,
  input  logic [IDX_W-1:0]  lookupTag,
  output logic              headReady,
  output entryKind_e        headKind,
  output logic              headMispredict,
  output logic [DEST_W-1:0] headDest,
  output logic [DATA_W-1:0] headValue,
  output logic              lookupHit,
  output logic [DATA_W-1:0] lookupValue
);

  logic [DEPTH-1:0] slotValid, slotReady, slotMis;
  entryKind_e       slotKind  [DEPTH];
  logic [DEST_W-1:0] slotDest [DEPTH];
  logic [DATA_W-1:0] slotValue[DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic hitAlloc, hitCommit, hitWb;
    assign hitAlloc  = strobe.alloc  && (allocIdx == IDX_W'(g));
    assign hitCommit = strobe.commit && (headIdx  == IDX_W'(g));
    assign hitWb     = wbValid && (wbTag == IDX_W'(g)) && slotValid[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slotValid[g] <= 1'b0;
        slotReady[g] <= 1'b0;
        slotMis[g]   <= 1'b0;
      end else if (strobe.flush) begin
        slotValid[g] <= 1'b0;
        slotReady[g] <= 1'b0;
        slotMis[g]   <= 1'b0;
      end else if (hitAlloc) begin
        slotValid[g] <= 1'b1;
        slotReady[g] <= 1'b0;
        slotMis[g]   <= 1'b0;
      end else if (hitCommit) begin
        slotValid[g] <= 1'b0;
        slotReady[g] <= 1'b0;
      end else if (hitWb) begin
        slotReady[g] <= 1'b1;
        slotMis[g]   <= wbMispredict;
      end
    end

    always_ff @(posedge clk) begin
      if (hitAlloc) begin
        slotKind[g] <= allocKind;
        slotDest[g] <= allocDest;
      end
      if (hitWb && !strobe.flush && !hitCommit) slotValue[g] <= wbValue;
    end
  end

  always_comb begin
    headReady      = slotValid[headIdx] && slotReady[headIdx];
    headKind       = slotKind[headIdx];
    headMispredict = slotMis[headIdx];
    headDest       = slotDest[headIdx];
    headValue      = slotValue[headIdx];
    lookupHit      = slotValid[lookupTag] && slotReady[lookupTag];
    lookupValue    = slotValue[lookupTag];
  end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import reorder_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  parameter  int DEST_W = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [DEST_W-1:0] issueDest,
  output logic              issueReady,
  output logic [IDX_W-1:0]  issueTag,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbMispredict,
  input  logic [IDX_W-1:0]  lookupTag,
  output logic              lookupHit,
  output logic [DATA_W-1:0] lookupValue,
  output logic              commitRegValid,
  output logic [DEST_W-1:0] commitRegDest,
  output logic [DATA_W-1:0] commitRegValue,
  output logic              commitStoreValid,
  output logic [DEST_W-1:0] commitStoreAddr,
  output logic [DATA_W-1:0] commitStoreData,
  output logic              redirectValid,
  output logic [DATA_W-1:0] redirectTarget
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  robStrobe_t        strobe;
  logic [IDX_W-1:0]  headIdx, tailIdx;
  logic [CNT_W-1:0]  occupancy;
  logic              headReady, headMispredict, retireNow;
  entryKind_e        headKind;
  logic [DEST_W-1:0] headDest;
  logic [DATA_W-1:0] headValue;

  reorder_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid),
    .headReady(headReady), .headKind(headKind), .headMispredict(headMispredict),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .occupancy(occupancy), .issueReady(issueReady)
  );

  reorder_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) i_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocIdx(tailIdx), .allocKind(entryKind_e'(issueKind)), .allocDest(issueDest),
    .headIdx(headIdx), .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue),
    .wbMispredict(wbMispredict), .lookupTag(lookupTag),
    .headReady(headReady), .headKind(headKind), .headMispredict(headMispredict),
    .headDest(headDest), .headValue(headValue),
    .lookupHit(lookupHit), .lookupValue(lookupValue)
  );

  assign retireNow        = strobe.commit;
  assign issueTag         = tailIdx;
  assign commitRegValid   = strobe.commit && (headKind == KIND_REG);
  assign commitRegDest    = headDest;
  assign commitRegValue   = headValue;
  assign commitStoreValid = strobe.commit && (headKind == KIND_STORE);
  assign commitStoreAddr  = headDest;
  assign commitStoreData  = headValue;
  assign redirectValid    = strobe.flush;
  assign redirectTarget   = headValue;

endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issueValid,
  input logic             issueReady,
  input logic [CNT_W-1:0] occupancy,
  input logic             retireNow,
  input logic             commitRegValid,
  input logic             commitStoreValid,
  input logic             redirectValid
);

  // R4: a full buffer refuses issue
  p_stall_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH)) |-> !issueReady);

  // R4: occupancy never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  // R5: at most one kind of retirement per cycle
  p_single_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commitRegValid, commitStoreValid, redirectValid}));

  // R8: flush empties the buffer and blocks issue in its cycle
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |=> (occupancy == '0));
  p_flush_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |-> !issueReady);

  // R2: an accepted issue without retirement grows occupancy by one
  p_issue_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueReady && !retireNow) |=> (occupancy == CNT_W'($past(occupancy) + 1'b1)));

  // R12: issue together with retirement keeps occupancy
  p_issue_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueReady && retireNow) |=> (occupancy == $past(occupancy)));

endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueReady(issueReady),
  .occupancy(occupancy), .retireNow(retireNow), .commitRegValid(commitRegValid),
  .commitStoreValid(commitStoreValid), .redirectValid(redirectValid)
);

// File: tb/test_reorder_buf.sv
`timescale 1ns/1ps
module test_reorder_buf;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueKind = 2'b00;
  logic [15:0] issueDest = '0;
  logic        issueReady;
  logic [2:0]  issueTag;
  logic        wbValid = 1'b0;
  logic [2:0]  wbTag = '0;
  logic [31:0] wbValue = '0;
  logic        wbMispredict = 1'b0;
  logic [2:0]  lookupTag = '0;
  logic        lookupHit;
  logic [31:0] lookupValue;
  logic        commitRegValid, commitStoreValid, redirectValid;
  logic [15:0] commitRegDest, commitStoreAddr;
  logic [31:0] commitRegValue, commitStoreData, redirectTarget;

  always #2 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .DATA_W(32), .DEST_W(16)) i_reorder_buf (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueKind(issueKind),
    .issueDest(issueDest), .issueReady(issueReady), .issueTag(issueTag),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue), .wbMispredict(wbMispredict),
    .lookupTag(lookupTag), .lookupHit(lookupHit), .lookupValue(lookupValue),
    .commitRegValid(commitRegValid), .commitRegDest(commitRegDest),
    .commitRegValue(commitRegValue), .commitStoreValid(commitStoreValid),
    .commitStoreAddr(commitStoreAddr), .commitStoreData(commitStoreData),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget)
  );

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 0;

  // retirement log: kind 0 reg, 1 store, 2 redirect
  logic [1:0]  logKind[$];
  logic [15:0] logDest[$];
  logic [31:0] logVal[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (commitRegValid)   begin logKind.push_back(2'd0); logDest.push_back(commitRegDest);   logVal.push_back(commitRegValue);  end
      if (commitStoreValid) begin logKind.push_back(2'd1); logDest.push_back(commitStoreAddr); logVal.push_back(commitStoreData); end
      if (redirectValid)    begin logKind.push_back(2'd2); logDest.push_back(16'h0);           logVal.push_back(redirectTarget);  end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logKind.delete(); logDest.delete(); logVal.delete();
  endtask

  task automatic doIssue(input logic [1:0] k, input logic [15:0] d, output logic [2:0] tag);
    @(negedge clk);
    issueValid = 1'b1; issueKind = k; issueDest = d;
    #0.1;
    tag = issueTag;
    check("R2 issue accepted", issueReady, 1'b1);
    @(posedge clk); #0.5;
    issueValid = 1'b0;
  endtask

  task automatic doWb(input logic [2:0] t, input logic [31:0] v, input logic mis);
    @(negedge clk);
    wbValid = 1'b1; wbTag = t; wbValue = v; wbMispredict = mis;
    @(posedge clk); #0.5;
    wbValid = 1'b0; wbMispredict = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic probe(input logic [2:0] t, output logic hit, output logic [31:0] val);
    @(negedge clk);
    lookupTag = t;
    #0.1;
    hit = lookupHit; val = lookupValue;
  endtask

  task automatic t_reset();
    check("R1 issueReady", issueReady, 1'b1);
    check("R1 issueTag", issueTag, 3'd0);
    check("R1 lookupHit", lookupHit, 1'b0);
    check("R1 commit outputs", {commitRegValid, commitStoreValid, redirectValid}, 3'b000);
  endtask

  task automatic t_inorder();
    logic [2:0] a, b, c; logic hit; logic [31:0] v;
    clearLog();
    doIssue(2'b00, 16'd5, a);
    doIssue(2'b00, 16'd6, b);
    doIssue(2'b00, 16'd7, c);
    check("R2 tag sequence", {a, b, c}, {3'd0, 3'd1, 3'd2});
    doWb(c, 32'h22, 1'b0);
    doWb(b, 32'h11, 1'b0);
    idle(2);
    check("R5 no retire before head", logKind.size(), 0);
    probe(c, hit, v);
    check("R10 lookup hit", hit, 1'b1);
    check("R10 lookup value", v, 32'h22);
    doWb(a, 32'h10, 1'b0);
    idle(4);
    check("R5 retire count", logKind.size(), 3);
    if (logKind.size() == 3) begin
      check("R6 order dest", {logDest[0], logDest[1], logDest[2]}, {16'd5, 16'd6, 16'd7});
      check("R6 order value", {logVal[0], logVal[1]}, {32'h10, 32'h11});
      check("R6 kind reg", {logKind[0], logKind[2]}, 4'b0000);
    end
    probe(c, hit, v);
    check("R10 miss after retire", hit, 1'b0);
  endtask

  task automatic t_store();
    logic [2:0] s;
    clearLog();
    doIssue(2'b01, 16'h40, s);
    check("R2 store tag", s, 3'd3);
    doWb(s, 32'hAB, 1'b0);
    idle(3);
    check("R7 store count", logKind.size(), 1);
    if (logKind.size() == 1) begin
      check("R7 R3 store kind", logKind[0], 2'd1);
      check("R7 store addr", logDest[0], 16'h40);
      check("R7 store data", logVal[0], 32'hAB);
    end
  endtask

  task automatic t_free_wb();
    logic hit; logic [31:0] v;
    clearLog();
    doWb(3'd6, 32'h99, 1'b0);
    idle(2);
    probe(3'd6, hit, v);
    check("R11 free slot wb ignored", hit, 1'b0);
    check("R11 no retire", logKind.size(), 0);
  endtask

  task automatic t_full();
    logic [2:0] t; logic hit; logic [31:0] v;
    clearLog();
    for (int i = 0; i < DEPTH - 1; i++) doIssue(2'b00, 16'(100 + i), t);
    probe(3'd6, hit, v);
    check("R11 reused slot incomplete", hit, 1'b0);
    check("R4 ready at depth-1", issueReady, 1'b1);
    doWb(3'd4, 32'h400, 1'b0);
    doIssue(2'b00, 16'd107, t);     // lands on the retire edge of tag 4
    check("R12 simultaneous tag", t, 3'd3);
    @(negedge clk); #0.1;
    check("R12 still one slot free", issueReady, 1'b1);
    doIssue(2'b00, 16'd108, t);
    check("R2 wrapped tag", t, 3'd4);
    @(negedge clk);
    issueValid = 1'b1; issueKind = 2'b00; issueDest = 16'hDEAD;
    #0.1;
    check("R4 full stalls issue", issueReady, 1'b0);
    @(posedge clk); #0.5;
    issueValid = 1'b0;
    for (int i = 0; i < DEPTH; i++) doWb(3'((5 + i) % DEPTH), 32'(16'h500 + i), 1'b0);
    idle(4);
    check("R4 R5 retire count", logKind.size(), 9);
    if (logKind.size() == 9)
      for (int i = 0; i < 9; i++) check("R5 drain order", logDest[i], 16'(100 + i));
  endtask

  task automatic t_branch_ok();
    logic [2:0] br, r;
    clearLog();
    doIssue(2'b10, 16'h0, br);
    doIssue(2'b00, 16'h33, r);
    check("R2 branch tags", {br, r}, {3'd5, 3'd6});
    doWb(r, 32'h66, 1'b0);
    doWb(br, 32'h500, 1'b0);
    idle(4);
    check("R9 only reg retires", logKind.size(), 1);
    if (logKind.size() == 1) begin
      check("R9 no redirect", logKind[0], 2'd0);
      check("R9 following dest", logDest[0], 16'h33);
    end
  endtask

  task automatic t_mispredict();
    logic [2:0] a, br, b, c, n; logic hit; logic [31:0] v;
    clearLog();
    doIssue(2'b00, 16'h41, a);
    doIssue(2'b10, 16'h0, br);
    doIssue(2'b00, 16'h42, b);
    doIssue(2'b00, 16'h43, c);
    check("R2 mispredict tags", {a, br, b, c}, {3'd7, 3'd0, 3'd1, 3'd2});
    doWb(c, 32'hC3, 1'b0);
    doWb(b, 32'hB2, 1'b0);
    doWb(br, 32'h1234, 1'b1);
    doWb(a, 32'h70, 1'b0);
    idle(5);
    check("R8 retire count", logKind.size(), 2);
    if (logKind.size() == 2) begin
      check("R8 older reg first", {logKind[0], logDest[0]}, {2'd0, 16'h41});
      check("R8 redirect", logKind[1], 2'd2);
      check("R8 redirect target", logVal[1], 32'h1234);
    end
    check("R8 empty after flush", issueReady, 1'b1);
    probe(b, hit, v);
    check("R8 younger flushed", hit, 1'b0);
    clearLog();
    doIssue(2'b00, 16'h55, n);
    check("R8 restart tag", n, 3'd1);
    doWb(n, 32'h5555, 1'b0);
    idle(3);
    check("R8 fresh retire", logKind.size(), 1);
    if (logKind.size() == 1) check("R8 fresh dest", logDest[0], 16'h55);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inorder();
    t_store();
    t_free_wb();
    t_full();
    t_branch_ok();
    t_mispredict();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule